// File: doc/BRIEF.md
# LPC Firmware Memory Target

This block is the target-side bus engine for a firmware memory on the LPC bus. It watches the 4-bit LAD nibble bus and the active-low frame strobe. It decodes single-byte memory read and memory write cycles that carry a 32-bit address. It accepts a cycle only when the address falls in one of two 16 MB windows and the 4-bit identification field in the address matches the board strap inputs. It then answers with the fixed response nibbles on LAD.

The block does not hold the storage. It issues a one-cycle request to a memory core next to it. The request carries a 19-bit byte address, a flag that selects the register space instead of the array, a direction, and the write byte. For reads, the core returns a byte with one cycle of latency. The LAD pads are modelled as separate input, output and output-enable signals.

Cycle numbering below counts clock periods: cycle 1 is the period whose closing rising edge samples the START nibble, and cycle k is the k-th period from there.

Top module: `lpc_fwmem_target`

## Requirements
- R1: After a synchronous reset, `lad_oe` and `mem_req` are 0 and the block waits for a START.
- R2: A cycle begins at a rising edge where `frame_n` is 0 and `lad_in` is 0000b. The next nibble is the type: bits 3:2 must be 01b, and bit 1 gives the direction (0 read, 1 write). A read also needs bit 0 = 0; for a write bit 0 is ignored. Any other type makes the block stay silent (no drive, no request) until the next START.
- R3: The address arrives in cycles 3 to 10 as eight nibbles, most significant first. `mem_addr` carries address bits 18:0.
- R4: If address bits 31:24 are all ones, `mem_is_reg` = NOT bit 23. If they are all zeros, `mem_is_reg` = bit 23. Any other value of bits 31:24 makes the cycle ignored.
- R5: Address bits 22:19 must equal `strap_id`, otherwise the cycle is ignored.
- R6: On an accepted read, the block does not drive in cycles 11 and 12. It then drives 0101b in cycles 13 and 14, 0000b in cycle 15, the data low nibble in cycle 16, the high nibble in cycle 17, and 1111b in cycle 18. From cycle 19 it releases LAD.
- R7: On an accepted read, `mem_req`=1 with `mem_we`=0 during cycle 11 only. `mem_rdata` is taken at the end of cycle 12, one cycle after the request edge, and this byte is what cycles 16 and 17 return.
- R8: On an accepted write, the data byte arrives in cycles 11 (low nibble) and 12 (high nibble). `mem_req`=1 with `mem_we`=1 and that byte on `mem_wdata` during cycle 13 only. The block drives 0000b in cycle 15 and 1111b in cycle 16, then releases LAD.
- R9: `frame_n`=0 during a cycle in progress aborts it. `lad_oe` is 0 in that same period and in the following one. A read aborted at or before cycle 10 gives no request. A write aborted at or before cycle 12 gives no request.
- R10: A write aborted in cycle 13 or 14 still delivers its request, and LAD is released at once.
- R11: A START (frame low with 0000b) that arrives while another cycle is in progress discards the old cycle and begins a new one from that edge.
- R12: `mem_req` is never high in two consecutive cycles, and it is 0 whenever LAD is driven by the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Frame strobe from host, active low |
| lad_in | input | 4 | Nibble sampled from LAD |
| lad_out | output | 4 | Nibble driven onto LAD |
| lad_oe | output | 1 | LAD output enable |
| strap_id | input | 4 | Board strap identification |
| mem_req | output | 1 | One-cycle access request to the core |
| mem_we | output | 1 | Request direction, 1 = write |
| mem_is_reg | output | 1 | 1 = register space, 0 = array |
| mem_addr | output | 19 | Byte address inside the device |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte from the core, one cycle after the request |

## Verification
The assertions assume the host holds `frame_n` high between START and the end of a cycle, except when it means to abort. They also assume the host never starts a new cycle while LAD is still driven, other than by an abort or a fresh START. The bench drives the host side only through whole-transaction tasks. These tasks produce legal nibble streams, with aborts and restarts placed only at chosen cycles, and they leave LAD at 1111b whenever the host would let it float. Random address windows, ID values, type nibbles and abort points are drawn from a fixed seed. The read data always comes from a one-cycle-latency memory model, so the assumptions on the core's side are kept.

// File: rtl/lpc_fw_pkg.sv
package lpc_fw_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  localparam logic [NIB_W-1:0] NIB_START = 4'h0;
  localparam logic [NIB_W-1:0] NIB_WAIT  = 4'h5;
  localparam logic [NIB_W-1:0] NIB_READY = 4'h0;
  localparam logic [NIB_W-1:0] NIB_TURN  = 4'hF;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TYPE,
    S_ADDR,
    S_WDAT,
    S_HTAR,
    S_WSYNC,
    S_RSYNC,
    S_RDAT,
    S_TTAR
  } lpc_state_e;

  function automatic logic type_ok(input logic [NIB_W-1:0] t);
    return (t[3:2] == 2'b01) && (t[1] || !t[0]);
  endfunction
endpackage

// File: rtl/lpc_fw_decode.sv
module lpc_fw_decode #(
  parameter int ADDR_W = 32,
  parameter int ARR_AW = 19,
  parameter int ID_W   = 4
) (
  input  logic [ADDR_W-1:0] addr_cand,
  input  logic [ID_W-1:0]   strap,
  output logic              hit,
  output logic              is_reg
);
  localparam int SEL_BIT = ARR_AW + ID_W;
  localparam int WIN_W   = ADDR_W - SEL_BIT - 1;

  logic [WIN_W-1:0] win;
  logic             win_top;
  logic             win_bot;
  logic             id_match;

  always_comb begin
    win      = addr_cand[ADDR_W-1:SEL_BIT+1];
    win_top  = &win;
    win_bot  = ~|win;
    id_match = (addr_cand[SEL_BIT-1:ARR_AW] == strap);
    hit      = (win_top || win_bot) && id_match;
    is_reg   = win_top ? ~addr_cand[SEL_BIT] : addr_cand[SEL_BIT];
  end
endmodule

// File: rtl/lpc_fw_seq.sv
module lpc_fw_seq
  import lpc_fw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ARR_AW = 19,
  parameter int WAIT_N = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_n,
  input  logic [NIB_W-1:0]    lad_in,
  output logic [ADDR_W-1:0]   addr_cand,
  input  logic                dec_hit,
  input  logic                dec_is_reg,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                drv_en,
  output logic [NIB_W-1:0]    drv_nib,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_is_reg,
  output logic [ARR_AW-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata
);
  localparam int NIBS    = ADDR_W / NIB_W;
  localparam int CNT_MAX = (NIBS > WAIT_N) ? NIBS : WAIT_N;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int SR_W    = ADDR_W - NIB_W;

  lpc_state_e         st, nxt;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic               is_wr;
  logic [SR_W-1:0]    addr_sr;
  logic [NIB_W-1:0]   lo_nib;
  logic [BYTE_W-1:0]  rd_byte;
  logic               last_addr;

  assign addr_cand = {addr_sr, lad_in};
  assign last_addr = (cnt == CNT_W'(NIBS - 1));

  always_comb begin
    nxt   = st;
    cnt_n = cnt;
    if (!frame_n) begin
      cnt_n = '0;
      nxt   = (lad_in == NIB_START) ? S_TYPE : S_IDLE;
    end else begin
      case (st)
        S_IDLE: nxt = S_IDLE;
        S_TYPE: begin
          cnt_n = '0;
          nxt   = type_ok(lad_in) ? S_ADDR : S_IDLE;
        end
        S_ADDR: begin
          if (last_addr) begin
            cnt_n = '0;
            nxt   = !dec_hit ? S_IDLE : (is_wr ? S_WDAT : S_HTAR);
          end else begin
            cnt_n = cnt + CNT_W'(1);
          end
        end
        S_WDAT: begin
          if (cnt == CNT_W'(1)) begin
            cnt_n = '0;
            nxt   = S_HTAR;
          end else begin
            cnt_n = cnt + CNT_W'(1);
          end
        end
        S_HTAR: begin
          if (cnt == CNT_W'(1)) begin
            cnt_n = '0;
            nxt   = is_wr ? S_RSYNC : S_WSYNC;
          end else begin
            cnt_n = cnt + CNT_W'(1);
          end
        end
        S_WSYNC: begin
          if (cnt == CNT_W'(WAIT_N - 1)) begin
            cnt_n = '0;
            nxt   = S_RSYNC;
          end else begin
            cnt_n = cnt + CNT_W'(1);
          end
        end
        S_RSYNC: begin
          cnt_n = '0;
          nxt   = is_wr ? S_TTAR : S_RDAT;
        end
        S_RDAT: begin
          if (cnt == CNT_W'(1)) begin
            cnt_n = '0;
            nxt   = S_TTAR;
          end else begin
            cnt_n = cnt + CNT_W'(1);
          end
        end
        S_TTAR:  nxt = S_IDLE;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_comb begin
    drv_en  = 1'b0;
    drv_nib = NIB_TURN;
    case (nxt)
      S_WSYNC: begin drv_en = 1'b1; drv_nib = NIB_WAIT;  end
      S_RSYNC: begin drv_en = 1'b1; drv_nib = NIB_READY; end
      S_RDAT: begin
        drv_en  = 1'b1;
        drv_nib = (cnt_n == '0) ? rd_byte[NIB_W-1:0] : rd_byte[BYTE_W-1:NIB_W];
      end
      S_TTAR:  begin drv_en = 1'b1; drv_nib = NIB_TURN;  end
      default: begin drv_en = 1'b0; drv_nib = NIB_TURN;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      is_wr      <= 1'b0;
      addr_sr    <= '0;
      lo_nib     <= '0;
      rd_byte    <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_is_reg <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      st      <= nxt;
      cnt     <= cnt_n;
      mem_req <= 1'b0;
      if (frame_n) begin
        case (st)
          S_TYPE: is_wr <= lad_in[1];
          S_ADDR: begin
            addr_sr <= addr_cand[SR_W-1:0];
            if (last_addr && dec_hit) begin
              mem_addr   <= addr_cand[ARR_AW-1:0];
              mem_is_reg <= dec_is_reg;
              if (!is_wr) begin
                mem_req <= 1'b1;
                mem_we  <= 1'b0;
              end
            end
          end
          S_WDAT: begin
            if (cnt == '0) begin
              lo_nib <= lad_in;
            end else begin
              mem_wdata <= {lad_in, lo_nib};
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
            end
          end
          S_HTAR: begin
            if (cnt == CNT_W'(1) && !is_wr) rd_byte <= mem_rdata;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lpc_fw_drive.sv
module lpc_fw_drive
  import lpc_fw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             drv_en,
  input  logic [NIB_W-1:0] drv_nib,
  output logic [NIB_W-1:0] lad_out,
  output logic             lad_oe
);
  logic             oe_q;
  logic [NIB_W-1:0] nib_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      nib_q <= NIB_TURN;
    end else begin
      oe_q  <= drv_en;
      nib_q <= drv_nib;
    end
  end

  assign lad_oe  = oe_q & frame_n;
  assign lad_out = nib_q;
endmodule

// File: rtl/lpc_fwmem_target.sv
module lpc_fwmem_target #(
  parameter int ADDR_W = 32,
  parameter int ARR_AW = 19,
  parameter int ID_W   = 4,
  parameter int WAIT_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  input  logic [ID_W-1:0]   strap_id,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_is_reg,
  output logic [ARR_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  logic [ADDR_W-1:0] addr_cand;
  logic              dec_hit;
  logic              dec_is_reg;
  logic              drv_en;
  logic [3:0]        drv_nib;

  lpc_fw_decode #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .ID_W(ID_W)) u_dec (
    .addr_cand (addr_cand),
    .strap     (strap_id),
    .hit       (dec_hit),
    .is_reg    (dec_is_reg)
  );

  lpc_fw_seq #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .WAIT_N(WAIT_N)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .frame_n    (frame_n),
    .lad_in     (lad_in),
    .addr_cand  (addr_cand),
    .dec_hit    (dec_hit),
    .dec_is_reg (dec_is_reg),
    .mem_rdata  (mem_rdata),
    .drv_en     (drv_en),
    .drv_nib    (drv_nib),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_is_reg (mem_is_reg),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  lpc_fw_drive u_drv (
    .clk     (clk),
    .rst     (rst),
    .frame_n (frame_n),
    .drv_en  (drv_en),
    .drv_nib (drv_nib),
    .lad_out (lad_out),
    .lad_oe  (lad_oe)
  );
endmodule

// File: rtl/lpc_fwmem_target_chk.sv
module lpc_fwmem_target_chk (
  input logic       clk,
  input logic       rst,
  input logic       frame_n,
  input logic [3:0] lad_out,
  input logic       lad_oe,
  input logic       mem_req,
  input logic       mem_we
);
  // R12: a request lasts a single cycle
  a_r12_req_single: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R12: no request while the block owns LAD
  a_r12_req_not_driving: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !lad_oe);

  // R9: frame low releases LAD now and in the next period
  a_r9_abort_now: assert property (@(posedge clk) disable iff (rst)
    !frame_n |-> !lad_oe);

  a_r9_abort_next: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> !lad_oe);

  // R6 and R8: the first driven nibble is always a sync code
  a_r6_first_sync: assert property (@(posedge clk) disable iff (rst)
    $rose(lad_oe) |-> (lad_out == 4'h5 || lad_out == 4'h0));

  // R6 and R8: an unaborted release follows a 1111b turnaround
  a_r6_release_after_turn: assert property (@(posedge clk) disable iff (rst)
    ($fell(lad_oe) && frame_n) |-> ($past(lad_out) == 4'hF));

  // R8: a write request never coincides with a read-side drive
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (!lad_oe && frame_n == frame_n));
endmodule

bind lpc_fwmem_target lpc_fwmem_target_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .frame_n (frame_n),
  .lad_out (lad_out),
  .lad_oe  (lad_oe),
  .mem_req (mem_req),
  .mem_we  (mem_we)
);

// File: tb/lpc_fwmem_target_bench.sv
module lpc_fwmem_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC         = 20;
  localparam logic [3:0] STRAP = 4'hA;

  logic        clk = 1'b0;
  logic        rst;
  logic        frame_n;
  logic [3:0]  lad_in;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        mem_req, mem_we, mem_is_reg;
  logic [18:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  int total = 0;
  int bad   = 0;
  int cyc_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_fwmem_target u_lpc_fwmem_target (
    .clk(clk), .rst(rst), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .strap_id(STRAP),
    .mem_req(mem_req), .mem_we(mem_we), .mem_is_reg(mem_is_reg),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory core model, one cycle read latency
  logic [7:0] bmem    [0:511];
  logic       written [0:511];
  logic [7:0] shadow  [0:511];

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37) + 11);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 512; i++) written[i] <= 1'b0;
      mem_rdata <= 8'h00;
    end else if (mem_req) begin
      if (mem_we) begin
        bmem[{mem_is_reg, mem_addr[7:0]}]    <= mem_wdata;
        written[{mem_is_reg, mem_addr[7:0]}] <= 1'b1;
      end else begin
        mem_rdata <= written[{mem_is_reg, mem_addr[7:0]}] ?
                     bmem[{mem_is_reg, mem_addr[7:0]}] : init_val({mem_is_reg, mem_addr[7:0]});
      end
    end
  end

  always @(posedge clk) begin
    cyc_count <= cyc_count + 1;
    if (cyc_count > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // per-transaction scripts
  logic       hf [0:NC];
  logic [3:0] hn [0:NC];
  logic       eo [0:NC];
  logic [3:0] en [0:NC];
  logic       ereq [0:NC];
  logic       ewe  [0:NC];
  logic       so [0:NC];
  logic [3:0] sn [0:NC];
  logic       sreq [0:NC];
  logic       swe  [0:NC];
  logic [18:0] cap_addr;
  logic        cap_isreg;
  logic [7:0]  cap_wdata;
  logic        exp_commit;
  logic        exp_hit_r;
  logic [18:0] e_addr;
  logic        e_isreg;
  logic [7:0]  e_wdata;
  logic [8:0]  e_idx;

  function automatic logic exp_type(input logic [3:0] t);
    return (t[3:2] == 2'b01) && (t[1] || !t[0]);
  endfunction
  function automatic logic exp_win(input logic [31:0] a);
    return (a[31:24] == 8'hFF) || (a[31:24] == 8'h00);
  endfunction
  function automatic logic exp_isreg(input logic [31:0] a);
    return (a[31:24] == 8'hFF) ? !a[23] : a[23];
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic build(input logic [3:0] t, input logic [31:0] a,
                       input logic [7:0] d, input int abort_at);
    logic hit;
    for (int c = 0; c <= NC; c++) begin
      hf[c] = 1'b1; hn[c] = 4'hF; eo[c] = 1'b0; en[c] = 4'h0;
      ereq[c] = 1'b0; ewe[c] = 1'b0;
    end
    hf[1] = 1'b0; hn[1] = 4'h0; hn[2] = t;
    for (int i = 0; i < 8; i++) hn[3+i] = a[31-4*i -: 4];
    if (t[1]) begin hn[11] = d[3:0]; hn[12] = d[7:4]; end
    hit = exp_type(t) && exp_win(a) && (a[22:19] == STRAP);
    exp_hit_r = hit;
    e_addr = a[18:0];
    e_isreg = exp_isreg(a);
    e_idx = {e_isreg, a[7:0]};
    e_wdata = d;
    if (hit && !t[1]) begin
      ereq[11] = 1'b1;
      eo[13] = 1; en[13] = 4'h5;
      eo[14] = 1; en[14] = 4'h5;
      eo[15] = 1; en[15] = 4'h0;
      eo[16] = 1; en[16] = shadow[e_idx][3:0];
      eo[17] = 1; en[17] = shadow[e_idx][7:4];
      eo[18] = 1; en[18] = 4'hF;
    end else if (hit) begin
      ereq[13] = 1'b1; ewe[13] = 1'b1;
      eo[15] = 1; en[15] = 4'h0;
      eo[16] = 1; en[16] = 4'hF;
    end
    if (abort_at != 0) begin
      hf[abort_at] = 1'b0; hn[abort_at] = 4'hF;
      for (int c = 1; c <= NC; c++) begin
        if (c >= abort_at) eo[c] = 1'b0;
        if (c > abort_at)  ereq[c] = 1'b0;
      end
    end
    exp_commit = hit && t[1] && ereq[13];
  endtask

  task automatic run_seq(input int n);
    for (int c = 1; c <= n; c++) begin
      @(negedge clk);
      frame_n = hf[c];
      lad_in  = hn[c];
      #1;
      so[c] = lad_oe; sn[c] = lad_out; sreq[c] = mem_req; swe[c] = mem_we;
      if (mem_req) begin
        cap_addr = mem_addr; cap_isreg = mem_is_reg; cap_wdata = mem_wdata;
      end
    end
  endtask

  task automatic check_seq(input int n, input string tag);
    logic ok_bus, ok_req, any_req;
    int   bc, rc;
    ok_bus = 1; ok_req = 1; any_req = 0; bc = 0; rc = 0;
    for (int c = n; c >= 1; c--) begin
      if (so[c] !== eo[c] || (eo[c] && sn[c] !== en[c])) begin ok_bus = 0; bc = c; end
      if (sreq[c] !== ereq[c] || (ereq[c] && swe[c] !== ewe[c])) begin ok_req = 0; rc = c; end
      if (ereq[c]) any_req = 1;
    end
    check(ok_bus, tag, $sformatf("LAD at cycle %0d", bc),
          {so[bc], 3'b0, sn[bc]}, {eo[bc], 3'b0, en[bc]});
    check(ok_req, "R12", $sformatf("request at cycle %0d (%s)", rc, tag),
          {sreq[rc], swe[rc]}, {ereq[rc], ewe[rc]});
    if (any_req && ok_req) begin
      check(cap_addr == e_addr, "R3", "mem_addr", cap_addr, e_addr);
      check(cap_isreg == e_isreg, "R4", "mem_is_reg", cap_isreg, e_isreg);
      if (ewe[11] || exp_commit)
        check(cap_wdata == e_wdata, "R8", "mem_wdata", cap_wdata, e_wdata);
    end
    if (exp_hit_r && !hn[2][1] && eo[17] && n >= 17)
      check({sn[17], sn[16]} == shadow[e_idx], "R7", "read byte",
            {sn[17], sn[16]}, shadow[e_idx]);
  endtask

  task automatic xact(input logic [3:0] t, input logic [31:0] a, input logic [7:0] d,
                      input int abort_at, input int n, input string tag);
    build(t, a, d, abort_at);
    run_seq(n);
    check_seq(n, tag);
    if (exp_commit && n >= 13) shadow[e_idx] = d;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); frame_n = 1'b1; lad_in = 4'hF;
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] w, input logic s,
                                     input logic [3:0] id, input logic [18:0] lo);
    return {w, s, id, lo};
  endfunction

  initial begin
    logic [3:0]  t;
    logic [31:0] a;
    logic [7:0]  d;
    int          ab;
    string       tag;
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 512; i++) shadow[i] = init_val(i);
    rst = 1'b1; frame_n = 1'b1; lad_in = 4'hF;
    repeat (4) @(negedge clk);
    #1;
    check(lad_oe == 1'b0 && mem_req == 1'b0, "R1", "reset outputs", {lad_oe, mem_req}, 0);
    @(negedge clk); rst = 1'b0;
    idle(2);

    // directed windows and decode
    xact(4'b0100, mk(8'hFF, 1'b1, STRAP, 19'h00012), 8'h00, 0, NC, "R6");
    xact(4'b0110, mk(8'h00, 1'b1, STRAP, 19'h00034), 8'hC3, 0, NC, "R8");
    xact(4'b0100, mk(8'h00, 1'b1, STRAP, 19'h00034), 8'h00, 0, NC, "R4");
    xact(4'b0100, mk(8'h00, 1'b0, STRAP, 19'h00034), 8'h00, 0, NC, "R4");
    xact(4'b0111, mk(8'hFF, 1'b0, STRAP, 19'h7FF05), 8'h5A, 0, NC, "R2");
    xact(4'b0100, mk(8'hFF, 1'b0, STRAP, 19'h7FF05), 8'h00, 0, NC, "R4");
    xact(4'b0100, mk(8'hFE, 1'b1, STRAP, 19'h00012), 8'h00, 0, NC, "R4");
    xact(4'b0110, mk(8'h80, 1'b1, STRAP, 19'h00012), 8'h77, 0, NC, "R4");
    xact(4'b0100, mk(8'hFF, 1'b1, 4'h3, 19'h00012), 8'h00, 0, NC, "R5");
    xact(4'b0110, mk(8'hFF, 1'b1, 4'hB, 19'h00012), 8'h99, 0, NC, "R5");
    xact(4'b0101, mk(8'hFF, 1'b1, STRAP, 19'h00012), 8'h00, 0, NC, "R2");
    xact(4'b0000, mk(8'hFF, 1'b1, STRAP, 19'h00012), 8'h00, 0, NC, "R2");
    xact(4'b1110, mk(8'hFF, 1'b1, STRAP, 19'h00012), 8'h11, 0, NC, "R2");
    // aborts
    xact(4'b0100, mk(8'hFF, 1'b1, STRAP, 19'h00040), 8'h00, 14, NC, "R9");
    xact(4'b0100, mk(8'hFF, 1'b1, STRAP, 19'h00040), 8'h00, 5, NC, "R9");
    xact(4'b0110, mk(8'hFF, 1'b1, STRAP, 19'h00041), 8'hE1, 12, NC, "R9");
    xact(4'b0110, mk(8'hFF, 1'b1, STRAP, 19'h00042), 8'hE2, 13, NC, "R10");
    xact(4'b0110, mk(8'hFF, 1'b1, STRAP, 19'h00043), 8'hE3, 14, NC, "R10");
    xact(4'b0100, mk(8'hFF, 1'b1, STRAP, 19'h00042), 8'h00, 0, NC, "R10");
    xact(4'b0100, mk(8'hFF, 1'b1, STRAP, 19'h00043), 8'h00, 0, NC, "R10");
    xact(4'b0100, mk(8'hFF, 1'b1, STRAP, 19'h00041), 8'h00, 0, NC, "R9");
    // restart while busy
    xact(4'b0110, mk(8'hFF, 1'b1, STRAP, 19'h00050), 8'h3C, 0, 7, "R11");
    xact(4'b0100, mk(8'hFF, 1'b1, STRAP, 19'h00050), 8'h00, 0, NC, "R11");
    xact(4'b0100, mk(8'hFF, 1'b1, STRAP, 19'h00012), 8'h00, 0, 12, "R11");
    xact(4'b0100, mk(8'h00, 1'b0, STRAP, 19'h00012), 8'h00, 0, NC, "R11");

    // constrained random
    for (int k = 0; k < 120; k++) begin
      int r;
      logic [7:0] w;
      logic [3:0] id;
      r = int'($urandom % 8);
      w = (r < 3) ? 8'hFF : (r < 6) ? 8'h00 : 8'($urandom);
      id = ($urandom % 6 == 0) ? 4'($urandom) : STRAP;
      a = mk(w, 1'($urandom), id, {11'($urandom), 8'($urandom % 24)});
      r = int'($urandom % 10);
      if (r < 4)      t = 4'b0100;
      else if (r < 8) t = {3'b011, 1'($urandom)};
      else            t = 4'($urandom);
      d = 8'($urandom);
      ab = ($urandom % 8 == 0) ? int'(2 + $urandom % 18) : 0;
      if (!exp_type(t))                  tag = "R2";
      else if (!exp_win(a))              tag = "R4";
      else if (a[22:19] != STRAP)        tag = "R5";
      else if (ab != 0)                  tag = "R9";
      else if (t[1])                     tag = "R8";
      else                               tag = "R6";
      xact(t, a, d, ab, NC, tag);
      idle(int'($urandom % 3));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule